// File: doc/BRIEF.md
# Nibble Datapath Register Set

This block holds the working registers of a 4-bit controller datapath. An accumulator `A` and a carry flip-flop sit together, so that the pair can be loaded from the ALU or rotated as a single 5-bit ring. A sub-accumulator `B` works as a scratch store and as a wrapping up/down counter. Two memory address registers `X` and `Y` each have a shadow register. A swap operation trades a register's contents with its shadow, which is used for stacking an address or for reaching a wider address space. `Y` can also count, so that a loop over several digits can step its address in the same cycle that the data bus is read at the current address.

The surrounding datapath drives the block every cycle with a 4-bit ALU result, the ALU carry-out, a 4-bit bus word and one encoded operation field per register. All register contents appear as registered outputs. A carry-test flag captures the carry on request. The ALU, the instruction decoder, the RAM array and the program counter all live outside the block.

Top module: `nib_regfile`

## Requirements
- R1: With a register's operation field at code 1 (load ALU), that register (`A`, `B`, `X` or `Y`) shows `alu_res` after the next rising clock edge.
- R2: When `acc_op` is 1 (load ALU), `cy_q` takes `alu_cy` on the same edge as `A` takes `alu_res`.
- R3: `cy_op` code 1 sets the carry and code 2 clears it. Code 0 and code 3 leave it unchanged. `cy_op` is obeyed only when `acc_op` is 0 (hold) or 2 (load bus). An ALU load or a rotate decides the carry on its own. A bus load leaves the carry unchanged.
- R4: With `acc_op` at 3 (rotate left), new `A` = {old `A`[2:0], old carry} and new carry = old `A`[3]. With `acc_op` at 4 (rotate right), new `A` = {old carry, old `A`[3:1]} and new carry = old `A`[0].
- R5: When `cy_test` is high, `cy_flag` captures the carry value that stood before that edge. When `cy_test` is low, `cy_flag` holds.
- R6: Register op code 3 (swap) exchanges `X` with `SPX` and `Y` with `SPY` in one edge. Shadows change only through a swap. On `B`, code 3 holds. On `X`, codes 4 and 5 hold.
- R7: On `B` and `Y`, code 4 increments and code 5 decrements, both modulo 16. `b_roll` / `y_roll` is high for exactly the one cycle after an increment from 15 or a decrement from 0, and low at every other time.
- R8: The register fields are independent. In one cycle `Y` may count while `A` loads `bus_in`, which is read at the address `y_q` shows before that edge.
- R9: Register op code 2 on `B`, `X` or `Y`, and `acc_op` code 2, load `bus_in`. Codes 6 and 7 on any register field, and codes 5 to 7 on `acc_op`, hold.
- R10: A synchronous active-high `rst` clears `A`, the carry, `cy_flag`, `B`, `X`, `SPX`, `Y`, `SPY` and both roll flags at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | DW | ALU result nibble |
| alu_cy | input | 1 | ALU carry-out |
| bus_in | input | DW | Data bus nibble |
| acc_op | input | 3 | Accumulator op: 0 hold, 1 ALU, 2 bus, 3 rotate left, 4 rotate right |
| cy_op | input | 2 | Carry op: 0 keep, 1 set, 2 clear |
| cy_test | input | 1 | Capture carry into `cy_flag` |
| b_op | input | 3 | B op: 0 hold, 1 ALU, 2 bus, 4 inc, 5 dec |
| x_op | input | 3 | X op: 0 hold, 1 ALU, 2 bus, 3 swap |
| y_op | input | 3 | Y op: 0 hold, 1 ALU, 2 bus, 3 swap, 4 inc, 5 dec |
| a_q | output | DW | Accumulator |
| cy_q | output | 1 | Carry flip-flop |
| cy_flag | output | 1 | Carry-test result |
| b_q | output | DW | Sub-accumulator / counter |
| b_roll | output | 1 | B counter wrapped on the previous edge |
| x_q | output | DW | X address register |
| spx_q | output | DW | X shadow |
| y_q | output | DW | Y address register |
| spy_q | output | DW | Y shadow |
| y_roll | output | 1 | Y counter wrapped on the previous edge |

## Verification
The two functions that meet in one cycle are a count step on `Y` and a bus load of `A` from the memory word that `Y` currently addresses. The bench models the memory as a fixed function of `y_q` that drives `bus_in`. It then issues several consecutive cycles with `y_op` set to increment and `acc_op` set to bus load, including a step across the wrap from 15 to 0. Each result is judged by requiring that `A` holds the word for the old address, that `Y` has advanced by one, and that `y_roll` rises only after the wrapping step. A second overlap, a rotate or an ALU load arriving together with a carry set or clear, is judged against the priority stated in R3.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int OPW  = 3;
  localparam int CYW  = 2;

  typedef enum logic [OPW-1:0] {
    ACC_HOLD = 3'd0,
    ACC_ALU  = 3'd1,
    ACC_BUS  = 3'd2,
    ACC_ROL  = 3'd3,
    ACC_ROR  = 3'd4
  } acc_op_e;

  typedef enum logic [CYW-1:0] {
    CY_KEEP = 2'd0,
    CY_SET  = 2'd1,
    CY_CLR  = 2'd2
  } cy_op_e;

  typedef enum logic [OPW-1:0] {
    RG_HOLD = 3'd0,
    RG_ALU  = 3'd1,
    RG_BUS  = 3'd2,
    RG_SWAP = 3'd3,
    RG_INC  = 3'd4,
    RG_DEC  = 3'd5
  } reg_op_e;
endpackage

// File: rtl/nib_acc_carry.sv
module nib_acc_carry
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  alu_res,
  input  logic           alu_cy,
  input  logic [DW-1:0]  bus_in,
  input  logic [OPW-1:0] acc_op,
  input  logic [CYW-1:0] cy_op,
  input  logic           cy_test,
  output logic [DW-1:0]  a_q,
  output logic           cy_q,
  output logic           cy_flag
);
  logic [DW-1:0] a_nx;
  logic          cy_nx;
  logic          ring_owns_cy;

  always_comb begin
    a_nx         = a_q;
    cy_nx        = cy_q;
    ring_owns_cy = 1'b0;
    case (acc_op)
      ACC_ALU: begin
        a_nx         = alu_res;
        cy_nx        = alu_cy;
        ring_owns_cy = 1'b1;
      end
      ACC_BUS: a_nx = bus_in;
      ACC_ROL: begin
        a_nx         = {a_q[DW-2:0], cy_q};
        cy_nx        = a_q[DW-1];
        ring_owns_cy = 1'b1;
      end
      ACC_ROR: begin
        a_nx         = {cy_q, a_q[DW-1:1]};
        cy_nx        = a_q[0];
        ring_owns_cy = 1'b1;
      end
      default: ;
    endcase
    if (!ring_owns_cy) begin
      if (cy_op == CY_SET)      cy_nx = 1'b1;
      else if (cy_op == CY_CLR) cy_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      cy_q    <= 1'b0;
      cy_flag <= 1'b0;
    end else begin
      a_q  <= a_nx;
      cy_q <= cy_nx;
      if (cy_test) cy_flag <= cy_q;
    end
  end

  p_alu_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_op == ACC_ALU) |=> (a_q == $past(alu_res) && cy_q == $past(alu_cy)));

  p_rotate_left_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_op == ACC_ROL) |=> ({cy_q, a_q} == {$past(a_q), $past(cy_q)}));

  p_rotate_right_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_op == ACC_ROR) |=> ({cy_q, a_q} == {$past(a_q[0]), $past(cy_q), $past(a_q[DW-1:1])}));

  p_carry_set_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_op == ACC_HOLD && cy_op == CY_SET) |=> cy_q);

  p_carry_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_op == ACC_BUS && cy_op == CY_CLR) |=> !cy_q);

  p_flag_capture_r5: assert property (@(posedge clk) disable iff (rst)
    cy_test |=> (cy_flag == $past(cy_q)));

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cy_test |=> $stable(cy_flag));

  p_clear_acc_r10: assert property (@(posedge clk)
    rst |=> (a_q == '0 && !cy_q && !cy_flag));
endmodule

// File: rtl/nib_reg.sv
module nib_reg
  import nib_pkg::*;
#(
  parameter int DW         = 4,
  parameter bit HAS_SHADOW = 1'b1,
  parameter bit HAS_COUNT  = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  alu_res,
  input  logic [DW-1:0]  bus_in,
  input  logic [OPW-1:0] op,
  output logic [DW-1:0]  q,
  output logic [DW-1:0]  sh_q,
  output logic           roll_q
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  logic [DW-1:0] q_nx;
  logic          roll_nx;

  always_comb begin
    q_nx    = q;
    roll_nx = 1'b0;
    case (op)
      RG_ALU: q_nx = alu_res;
      RG_BUS: q_nx = bus_in;
      RG_SWAP: if (HAS_SHADOW) q_nx = sh_q;
      RG_INC: if (HAS_COUNT) begin
        q_nx    = q + 1'b1;
        roll_nx = (q == TOP);
      end
      RG_DEC: if (HAS_COUNT) begin
        q_nx    = q - 1'b1;
        roll_nx = (q == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      roll_q <= 1'b0;
    end else begin
      q      <= q_nx;
      roll_q <= roll_nx;
    end
  end

  generate
    if (HAS_SHADOW) begin : g_shadow
      logic [DW-1:0] sh_r;
      always_ff @(posedge clk) begin
        if (rst)                sh_r <= '0;
        else if (op == RG_SWAP) sh_r <= q;
      end
      assign sh_q = sh_r;

      p_swap_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (op == RG_SWAP) |=> (q == $past(sh_q) && sh_q == $past(q)));

      p_shadow_still_r6: assert property (@(posedge clk) disable iff (rst)
        (op != RG_SWAP) |=> $stable(sh_q));
    end else begin : g_no_shadow
      assign sh_q = '0;

      p_swap_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (op == RG_SWAP) |=> $stable(q));
    end
  endgenerate

  generate
    if (HAS_COUNT) begin : g_count_chk
      p_wrap_up_r7: assert property (@(posedge clk) disable iff (rst)
        (op == RG_INC && q == TOP) |=> (q == '0 && roll_q));

      p_wrap_down_r7: assert property (@(posedge clk) disable iff (rst)
        (op == RG_DEC && q == '0) |=> (q == TOP && roll_q));
    end else begin : g_no_count_chk
      p_count_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (op == RG_INC || op == RG_DEC) |=> $stable(q));
    end
  endgenerate

  p_roll_cause_r7: assert property (@(posedge clk) disable iff (rst)
    roll_q |-> ($past(op) == RG_INC || $past(op) == RG_DEC));

  p_alu_load_r1: assert property (@(posedge clk) disable iff (rst)
    (op == RG_ALU) |=> (q == $past(alu_res)));

  p_bus_load_r9: assert property (@(posedge clk) disable iff (rst)
    (op == RG_BUS) |=> (q == $past(bus_in)));

  p_clear_reg_r10: assert property (@(posedge clk)
    rst |=> (q == '0 && sh_q == '0 && !roll_q));
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  alu_res,
  input  logic           alu_cy,
  input  logic [DW-1:0]  bus_in,
  input  logic [2:0]     acc_op,
  input  logic [1:0]     cy_op,
  input  logic           cy_test,
  input  logic [2:0]     b_op,
  input  logic [2:0]     x_op,
  input  logic [2:0]     y_op,
  output logic [DW-1:0]  a_q,
  output logic           cy_q,
  output logic           cy_flag,
  output logic [DW-1:0]  b_q,
  output logic           b_roll,
  output logic [DW-1:0]  x_q,
  output logic [DW-1:0]  spx_q,
  output logic [DW-1:0]  y_q,
  output logic [DW-1:0]  spy_q,
  output logic           y_roll
);
  logic [DW-1:0] b_sh_unused;
  logic          x_roll_unused;

  nib_acc_carry #(.DW(DW)) i_acc (
    .clk(clk), .rst(rst), .alu_res(alu_res), .alu_cy(alu_cy),
    .bus_in(bus_in), .acc_op(acc_op), .cy_op(cy_op), .cy_test(cy_test),
    .a_q(a_q), .cy_q(cy_q), .cy_flag(cy_flag)
  );

  nib_reg #(.DW(DW), .HAS_SHADOW(1'b0), .HAS_COUNT(1'b1)) i_breg (
    .clk(clk), .rst(rst), .alu_res(alu_res), .bus_in(bus_in), .op(b_op),
    .q(b_q), .sh_q(b_sh_unused), .roll_q(b_roll)
  );

  nib_reg #(.DW(DW), .HAS_SHADOW(1'b1), .HAS_COUNT(1'b0)) i_xreg (
    .clk(clk), .rst(rst), .alu_res(alu_res), .bus_in(bus_in), .op(x_op),
    .q(x_q), .sh_q(spx_q), .roll_q(x_roll_unused)
  );

  nib_reg #(.DW(DW), .HAS_SHADOW(1'b1), .HAS_COUNT(1'b1)) i_yreg (
    .clk(clk), .rst(rst), .alu_res(alu_res), .bus_in(bus_in), .op(y_op),
    .q(y_q), .sh_q(spy_q), .roll_q(y_roll)
  );

  p_count_with_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    (y_op == RG_INC && acc_op == ACC_BUS) |=>
      (a_q == $past(bus_in) && y_q == $past(y_q) + 1'b1));

  p_x_apart_from_y_r8: assert property (@(posedge clk) disable iff (rst)
    (x_op == RG_HOLD && y_op == RG_SWAP) |=> ($stable(x_q) && $stable(spx_q)));
endmodule

// File: tb/test_nib_regfile.sv
`timescale 1ns/100ps
module test_nib_regfile;
  typedef struct packed {
    logic [2:0] aop;
    logic [1:0] cop;
    logic       ct;
    logic [2:0] bop;
    logic [2:0] xop;
    logic [2:0] yop;
    logic [3:0] alu;
    logic       alucy;
    logic [3:0] bus;
  } vec_t;

  function automatic vec_t mk(input logic [2:0] aop, input logic [1:0] cop, input logic ct,
                              input logic [2:0] bop, input logic [2:0] xop, input logic [2:0] yop,
                              input logic [3:0] alu, input logic alucy, input logic [3:0] bus);
    vec_t v;
    v.aop = aop; v.cop = cop; v.ct = ct; v.bop = bop; v.xop = xop; v.yop = yop;
    v.alu = alu; v.alucy = alucy; v.bus = bus;
    return v;
  endfunction

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    mk(3'd1, 2'd0, 1'b0, 3'd1, 3'd1, 3'd1, 4'h9, 1'b1, 4'h0),
    mk(3'd3, 2'd0, 1'b0, 3'd2, 3'd2, 3'd2, 4'h0, 1'b0, 4'h5),
    mk(3'd4, 2'd0, 1'b1, 3'd3, 3'd3, 3'd3, 4'h0, 1'b0, 4'h0),
    mk(3'd0, 2'd2, 1'b0, 3'd5, 3'd0, 3'd5, 4'h0, 1'b0, 4'h0),
    mk(3'd1, 2'd1, 1'b0, 3'd0, 3'd0, 3'd4, 4'h6, 1'b0, 4'h0),
    mk(3'd2, 2'd1, 1'b1, 3'd4, 3'd4, 3'd0, 4'h0, 1'b0, 4'hC),
    mk(3'd0, 2'd3, 1'b0, 3'd0, 3'd5, 3'd0, 4'h0, 1'b0, 4'h0),
    mk(3'd5, 2'd0, 1'b0, 3'd6, 3'd7, 3'd7, 4'h1, 1'b1, 4'h2),
    mk(3'd4, 2'd1, 1'b0, 3'd0, 3'd3, 3'd0, 4'h0, 1'b0, 4'h0),
    mk(3'd3, 2'd2, 1'b1, 3'd1, 3'd0, 3'd3, 4'hF, 1'b0, 4'h0),
    mk(3'd3, 2'd0, 1'b0, 3'd4, 3'd0, 3'd0, 4'h0, 1'b0, 4'h0),
    mk(3'd3, 2'd0, 1'b1, 3'd4, 3'd2, 3'd2, 4'h0, 1'b0, 4'hA),
    mk(3'd2, 2'd2, 1'b0, 3'd5, 3'd3, 3'd5, 4'h0, 1'b0, 4'h7),
    mk(3'd0, 2'd1, 1'b1, 3'd5, 3'd1, 3'd4, 4'h3, 1'b1, 4'h0),
    mk(3'd6, 2'd0, 1'b1, 3'd7, 3'd6, 3'd6, 4'hE, 1'b1, 4'hB),
    mk(3'd1, 2'd2, 1'b0, 3'd2, 3'd3, 3'd1, 4'h0, 1'b1, 4'h8)
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] alu_res = '0, bus_drv = '0;
  logic       alu_cy = 1'b0, cy_test = 1'b0, use_ram = 1'b0;
  logic [2:0] acc_op = '0, b_op = '0, x_op = '0, y_op = '0;
  logic [1:0] cy_op = '0;
  logic [3:0] bus_in, a_q, b_q, x_q, spx_q, y_q, spy_q;
  logic       cy_q, cy_flag, b_roll, y_roll;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [3:0] ma, mb, mx, mspx, my, mspy;
  logic       mcy, mflag, mbr, myr;

  always #2.5 clk = ~clk;

  function automatic logic [3:0] ram_of(input logic [3:0] adr);
    return {adr[0], adr[3:1]} ^ 4'hA;
  endfunction

  assign bus_in = use_ram ? ram_of(y_q) : bus_drv;

  nib_regfile #(.DW(4)) i_nib_regfile (
    .clk(clk), .rst(rst), .alu_res(alu_res), .alu_cy(alu_cy), .bus_in(bus_in),
    .acc_op(acc_op), .cy_op(cy_op), .cy_test(cy_test), .b_op(b_op), .x_op(x_op),
    .y_op(y_op), .a_q(a_q), .cy_q(cy_q), .cy_flag(cy_flag), .b_q(b_q),
    .b_roll(b_roll), .x_q(x_q), .spx_q(spx_q), .y_q(y_q), .spy_q(spy_q),
    .y_roll(y_roll)
  );

  task automatic chk(input string tag, input string nm, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
    end
  endtask

  task automatic model_clear();
    ma = '0; mb = '0; mx = '0; mspx = '0; my = '0; mspy = '0;
    mcy = 1'b0; mflag = 1'b0; mbr = 1'b0; myr = 1'b0;
  endtask

  task automatic model_step(input vec_t v, input logic [3:0] busv);
    logic [3:0] na, nb, nx, nspx, ny, nspy;
    logic ncy, nflag, nbr, nyr, cyown;
    na = ma; ncy = mcy; cyown = 1'b0;
    case (v.aop)
      3'd1: begin na = v.alu; ncy = v.alucy; cyown = 1'b1; end
      3'd2: na = busv;
      3'd3: begin na = {ma[2:0], mcy}; ncy = ma[3]; cyown = 1'b1; end
      3'd4: begin na = {mcy, ma[3:1]}; ncy = ma[0]; cyown = 1'b1; end
      default: ;
    endcase
    if (!cyown && v.cop == 2'd1) ncy = 1'b1;
    if (!cyown && v.cop == 2'd2) ncy = 1'b0;
    nflag = v.ct ? mcy : mflag;
    nb = mb; nbr = 1'b0;
    case (v.bop)
      3'd1: nb = v.alu;
      3'd2: nb = busv;
      3'd4: begin nb = mb + 4'd1; nbr = (mb == 4'hF); end
      3'd5: begin nb = mb - 4'd1; nbr = (mb == 4'h0); end
      default: ;
    endcase
    nx = mx; nspx = mspx;
    case (v.xop)
      3'd1: nx = v.alu;
      3'd2: nx = busv;
      3'd3: begin nx = mspx; nspx = mx; end
      default: ;
    endcase
    ny = my; nspy = mspy; nyr = 1'b0;
    case (v.yop)
      3'd1: ny = v.alu;
      3'd2: ny = busv;
      3'd3: begin ny = mspy; nspy = my; end
      3'd4: begin ny = my + 4'd1; nyr = (my == 4'hF); end
      3'd5: begin ny = my - 4'd1; nyr = (my == 4'h0); end
      default: ;
    endcase
    ma = na; mcy = ncy; mflag = nflag; mb = nb; mbr = nbr;
    mx = nx; mspx = nspx; my = ny; mspy = nspy; myr = nyr;
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "a_q", {4'h0, a_q}, {4'h0, ma});
    chk(tag, "cy_q", {7'h0, cy_q}, {7'h0, mcy});
    chk(tag, "cy_flag", {7'h0, cy_flag}, {7'h0, mflag});
    chk(tag, "b_q", {4'h0, b_q}, {4'h0, mb});
    chk(tag, "b_roll", {7'h0, b_roll}, {7'h0, mbr});
    chk(tag, "x_q", {4'h0, x_q}, {4'h0, mx});
    chk(tag, "spx_q", {4'h0, spx_q}, {4'h0, mspx});
    chk(tag, "y_q", {4'h0, y_q}, {4'h0, my});
    chk(tag, "spy_q", {4'h0, spy_q}, {4'h0, mspy});
    chk(tag, "y_roll", {7'h0, y_roll}, {7'h0, myr});
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.aop == 3'd3 || v.aop == 3'd4) return "R4";
    if (v.bop == 3'd4 || v.bop == 3'd5 || v.yop == 3'd4 || v.yop == 3'd5) return "R7";
    if (v.xop == 3'd3 || v.yop == 3'd3) return "R6";
    if (v.ct) return "R5";
    if (v.cop != 2'd0) return "R3";
    if (v.aop == 3'd1) return "R2";
    if (v.aop == 3'd2 || v.bop == 3'd2) return "R9";
    return "R1";
  endfunction

  // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge.
  task automatic step(input vec_t v, input string tag);
    acc_op = v.aop; cy_op = v.cop; cy_test = v.ct;
    b_op = v.bop; x_op = v.xop; y_op = v.yop;
    alu_res = v.alu; alu_cy = v.alucy; bus_drv = v.bus;
    model_step(v, use_ram ? ram_of(my) : v.bus);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] old_y;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare_all("R10 reset state");

    // Vector walk
    for (int i = 0; i < NV; i++) step(VEC[i], tag_of(VEC[i]));

    // R1: ALU load into every register at once, distinct pattern
    step(mk(3'd1, 2'd0, 1'b0, 3'd1, 3'd1, 3'd1, 4'h5, 1'b0, 4'h0), "R1");
    chk("R1", "b_q direct", {4'h0, b_q}, 8'h05);

    // R3: rotate beats carry clear
    step(mk(3'd2, 2'd1, 1'b0, 3'd0, 3'd0, 3'd0, 4'h0, 1'b0, 4'h8), "R3");
    step(mk(3'd3, 2'd2, 1'b0, 3'd0, 3'd0, 3'd0, 4'h0, 1'b0, 4'h0), "R3");
    chk("R3", "a after rol", {4'h0, a_q}, 8'h01);
    chk("R3", "cy after rol with clear", {7'h0, cy_q}, 8'h01);

    // R7: B decrement from 0 wraps, flag lasts one cycle
    step(mk(3'd0, 2'd0, 1'b0, 3'd1, 3'd0, 3'd0, 4'h0, 1'b0, 4'h0), "R7");
    step(mk(3'd0, 2'd0, 1'b0, 3'd5, 3'd0, 3'd0, 4'h0, 1'b0, 4'h0), "R7");
    chk("R7", "b wrap value", {4'h0, b_q}, 8'h0F);
    chk("R7", "b_roll high", {7'h0, b_roll}, 8'h01);
    step(mk(3'd0, 2'd0, 1'b0, 3'd0, 3'd0, 3'd0, 4'h0, 1'b0, 4'h0), "R7");
    chk("R7", "b_roll low again", {7'h0, b_roll}, 8'h00);

    // R8: Y counts while A fetches the word at the old address
    step(mk(3'd0, 2'd0, 1'b0, 3'd0, 3'd0, 3'd1, 4'hD, 1'b0, 4'h0), "R8");
    use_ram = 1'b1;
    for (int k = 0; k < 5; k++) begin
      old_y = y_q;
      step(mk(3'd2, 2'd0, 1'b0, 3'd0, 3'd0, 3'd4, 4'h0, 1'b0, 4'h0), "R8");
      chk("R8", "a fetched at old y", {4'h0, a_q}, {4'h0, ram_of(old_y)});
      chk("R8", "y advanced", {4'h0, y_q}, {4'h0, old_y + 4'd1});
      chk("R8", "y_roll", {7'h0, y_roll}, {7'h0, (old_y == 4'hF)});
    end
    use_ram = 1'b0;

    // R10: reset in the middle with active ops
    step(mk(3'd1, 2'd1, 1'b1, 3'd1, 3'd3, 3'd3, 4'h7, 1'b1, 4'h0), "R10 preload");
    rst = 1'b1;
    acc_op = 3'd1; b_op = 3'd4; x_op = 3'd3; y_op = 3'd4; cy_op = 2'd1; cy_test = 1'b1;
    model_clear();
    @(negedge clk);
    rst = 1'b0;
    acc_op = '0; b_op = '0; x_op = '0; y_op = '0; cy_op = '0; cy_test = 1'b0;
    compare_all("R10 mid reset");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule